// File: doc/BRIEF.md
# Packed Single-Precision to Unsigned Integer Converter

This block turns a vector of sixteen IEEE-754 single-precision values into sixteen unsigned 32-bit integers in one operation. The operation is issued by pulsing `op_valid` together with the source vector, the previous destination contents, a 16-bit write mask and the control bits. The converted, masked vector and its exception flags are registered and appear one cycle later. Lane *i* occupies bits `[32*i+31 : 32*i]` of every vector port.

Each lane picks its rounding direction from one of two places. The global rounding field `glob_rc` is used by default. When `static_rc_en` is high, the per-operation code `static_rc` takes its place and the operation also runs silent: it reports no flags and leaves the sticky status alone. A broadcast option feeds lane 0 of the source to every lane. A lane that cannot be represented returns all-ones. Lanes whose mask bit is clear either keep the old destination value or are cleared to zero.

The output control is a two-state machine. `ST_IDLE` means no result is present. `ST_DONE` means a result was captured on the last edge. The transition `ST_IDLE/ST_DONE -> ST_DONE` is taken when `op_valid` is high, and the transition `ST_IDLE/ST_DONE -> ST_IDLE` is taken when it is low.

Top module: `pcvt_f2u_vec`

## Requirements
- R1: `res_valid` is high exactly in the cycle after a cycle with `op_valid` high, and `res_vec` and the per-operation flags belong to that operation. After reset, `res_valid`, `res_vec`, `res_invalid`, `res_inexact` and both sticky flags are 0.
- R2: Rounding codes are 0 = nearest, ties to even; 1 = toward minus infinity; 2 = toward plus infinity; 3 = toward zero. Example: 2.5 gives 2, 2, 3, 2 and 1.5 gives 2, 1, 2, 1.
- R3: When `static_rc_en` is 1, `static_rc` selects the rounding and `glob_rc` has no effect. Otherwise `glob_rc` selects it.
- R4: A lane is invalid when its input is NaN, is infinite, or rounds to 2^32 or more or to a negative nonzero value. An invalid lane returns 0xFFFFFFFF. A negative input that rounds to zero returns 0 and is not invalid.
- R5: With `zero_en` = 0, a lane whose `wr_mask` bit is 0 returns the matching lane of `old_dst`.
- R6: With `zero_en` = 1, a lane whose `wr_mask` bit is 0 returns 0.
- R7: With `bcast_en` = 1, every lane converts bits [31:0] of `src_vec`, and the other source lanes are ignored.
- R8: `res_invalid` is the OR of the invalid conditions of the written lanes. `res_inexact` is the OR over written, non-invalid lanes that lost precision. Masked-off lanes never raise either flag.
- R9: With `static_rc_en` = 1, `res_invalid` and `res_inexact` read 0 and both sticky flags keep their values, but invalid lanes still return 0xFFFFFFFF.
- R10: `sticky_invalid` and `sticky_inexact` OR in the per-operation flags of every operation issued without the override. Only reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue one conversion this cycle |
| src_vec | input | 512 | Sixteen FP32 source lanes |
| old_dst | input | 512 | Previous destination lanes, used when merging |
| wr_mask | input | 16 | Per-lane write enable |
| zero_en | input | 1 | 1: masked lanes are cleared, 0: masked lanes are kept |
| bcast_en | input | 1 | Replicate source lane 0 to all lanes |
| static_rc_en | input | 1 | Use the static rounding code and suppress flags |
| static_rc | input | 2 | Per-operation rounding code |
| glob_rc | input | 2 | Global rounding field |
| res_valid | output | 1 | Result present (state `ST_DONE`) |
| res_vec | output | 512 | Sixteen unsigned 32-bit results |
| res_invalid | output | 1 | Invalid flag of the last operation |
| res_inexact | output | 1 | Inexact flag of the last operation |
| sticky_invalid | output | 1 | Accumulated invalid status |
| sticky_inexact | output | 1 | Accumulated inexact status |

## Verification
Any internal fault is visible at the ports one cycle after the issuing cycle, because every result is registered exactly once.

- A wrong rounding select shows up as an off-by-one integer in the halfway and ±0.5 lanes.
- A bad range decision shows up in two places: the lanes at the 2^32 boundary and the negative-to-zero lanes either flip to 0xFFFFFFFF or fail to, and the invalid flag follows them.
- A broken mask path or flag path corrupts the merged or zeroed lanes, or raises a flag from a lane that was not written.
- A sticky register that is updated under the override shows the stale value after the next operation, and stays that way until reset.

// File: rtl/f2u_pkg.sv
package f2u_pkg;
    typedef enum logic [1:0] {
        RC_NEAR = 2'd0,
        RC_DOWN = 2'd1,
        RC_UP   = 2'd2,
        RC_ZERO = 2'd3
    } rc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } out_st_e;

    localparam int unsigned FP_W     = 32;
    localparam int unsigned EXP_BIAS = 127;
    localparam int unsigned MAN_W    = 23;
    localparam int unsigned INT_PT   = EXP_BIAS + MAN_W;
endpackage

// File: rtl/f2u_lane.sv
module f2u_lane
    import f2u_pkg::*;
(
    input  logic [FP_W-1:0] fp_in,
    input  rc_e             rc,
    output logic [FP_W-1:0] u_out,
    output logic            inv,
    output logic            inx
);
    localparam int unsigned FRAC_W = 40;
    localparam int unsigned SIG_W  = MAN_W + 1;
    localparam int unsigned EXT_W  = SIG_W + FRAC_W;

    logic             sgn, is_spec, big, guard, stk, up, lost;
    logic [7:0]       ex, sh;
    logic [SIG_W-1:0] sig;
    logic [EXT_W-1:0] ext;
    logic [FP_W:0]    ints, rnd;

    always_comb begin
        sgn     = fp_in[31];
        ex      = fp_in[30:23];
        sig     = {|ex, fp_in[22:0]};
        is_spec = &ex;
        big     = 1'b0;
        guard   = 1'b0;
        stk     = 1'b0;
        ints    = '0;
        ext     = '0;
        sh      = '0;
        if (ex >= 8'(INT_PT)) begin
            sh = ex - 8'(INT_PT);
            if (sh > 8'd8) big = 1'b1;
            else           ints = {9'b0, sig} << sh[3:0];
        end else begin
            sh = 8'(INT_PT) - ex;
            if (sh > 8'(FRAC_W)) begin
                stk = |sig;
            end else begin
                ext   = {sig, {FRAC_W{1'b0}}} >> sh[5:0];
                ints  = {9'b0, ext[EXT_W-1:FRAC_W]};
                guard = ext[FRAC_W-1];
                stk   = |ext[FRAC_W-2:0];
            end
        end
        lost = guard | stk;
        unique case (rc)
            RC_NEAR: up = guard & (stk | ints[0]);
            RC_DOWN: up = sgn & lost;
            RC_UP:   up = ~sgn & lost;
            RC_ZERO: up = 1'b0;
            default: up = 1'b0;
        endcase
        rnd   = ints + {{FP_W{1'b0}}, up};
        inv   = is_spec | big | (sgn ? (rnd != '0) : rnd[FP_W]);
        u_out = inv ? '1 : (sgn ? '0 : rnd[FP_W-1:0]);
        inx   = lost & ~inv;
    end
endmodule

// File: rtl/f2u_mask_merge.sv
module f2u_mask_merge
    import f2u_pkg::*;
#(
    parameter int unsigned LANES = 16
) (
    input  logic [LANES*FP_W-1:0] conv,
    input  logic [LANES*FP_W-1:0] old,
    input  logic [LANES-1:0]      mask,
    input  logic                  zero_en,
    input  logic [LANES-1:0]      lane_inv,
    input  logic [LANES-1:0]      lane_inx,
    output logic [LANES*FP_W-1:0] merged,
    output logic                  any_inv,
    output logic                  any_inx
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            if (mask[i])      merged[i*FP_W +: FP_W] = conv[i*FP_W +: FP_W];
            else if (zero_en) merged[i*FP_W +: FP_W] = '0;
            else              merged[i*FP_W +: FP_W] = old[i*FP_W +: FP_W];
        end
    end

    assign any_inv = |(lane_inv & mask);
    assign any_inx = |(lane_inx & mask);
endmodule

// File: rtl/pcvt_f2u_vec.sv
module pcvt_f2u_vec
    import f2u_pkg::*;
#(
    parameter int unsigned LANES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  logic [LANES*32-1:0]   src_vec,
    input  logic [LANES*32-1:0]   old_dst,
    input  logic [LANES-1:0]      wr_mask,
    input  logic                  zero_en,
    input  logic                  bcast_en,
    input  logic                  static_rc_en,
    input  logic [1:0]            static_rc,
    input  logic [1:0]            glob_rc,
    output logic                  res_valid,
    output logic [LANES*32-1:0]   res_vec,
    output logic                  res_invalid,
    output logic                  res_inexact,
    output logic                  sticky_invalid,
    output logic                  sticky_inexact
);
    localparam int unsigned VW = LANES * FP_W;

    out_st_e          st_q, st_d;
    rc_e              rc_eff;
    logic [VW-1:0]    src_sel, conv, merged;
    logic [LANES-1:0] l_inv, l_inx;
    logic             any_inv, any_inx, op_inv, op_inx;

    assign rc_eff = static_rc_en ? rc_e'(static_rc) : rc_e'(glob_rc);

    for (genvar i = 0; i < LANES; i++) begin : g_cvt
        assign src_sel[i*FP_W +: FP_W] = bcast_en ? src_vec[FP_W-1:0]
                                                  : src_vec[i*FP_W +: FP_W];
        f2u_lane u_lane (
            .fp_in (src_sel[i*FP_W +: FP_W]),
            .rc    (rc_eff),
            .u_out (conv[i*FP_W +: FP_W]),
            .inv   (l_inv[i]),
            .inx   (l_inx[i])
        );
    end

    f2u_mask_merge #(.LANES(LANES)) u_merge (
        .conv     (conv),
        .old      (old_dst),
        .mask     (wr_mask),
        .zero_en  (zero_en),
        .lane_inv (l_inv),
        .lane_inx (l_inx),
        .merged   (merged),
        .any_inv  (any_inv),
        .any_inx  (any_inx)
    );

    assign op_inv = any_inv & ~static_rc_en;
    assign op_inx = any_inx & ~static_rc_en;

    always_comb begin
        unique case (st_q)
            ST_IDLE: st_d = op_valid ? ST_DONE : ST_IDLE;
            ST_DONE: st_d = op_valid ? ST_DONE : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vec        <= '0;
            res_invalid    <= 1'b0;
            res_inexact    <= 1'b0;
            sticky_invalid <= 1'b0;
            sticky_inexact <= 1'b0;
        end else if (op_valid) begin
            res_vec        <= merged;
            res_invalid    <= op_inv;
            res_inexact    <= op_inx;
            sticky_invalid <= sticky_invalid | op_inv;
            sticky_inexact <= sticky_inexact | op_inx;
        end
    end

    assign res_valid = (st_q == ST_DONE);

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);
    p_idle_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);
    p_merge_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !zero_en && !wr_mask[0]) |=> res_vec[31:0] == $past(old_dst[31:0]));
    p_zero_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && zero_en && !wr_mask[0]) |=> res_vec[31:0] == '0);
    p_silent_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && static_rc_en) |=> ($stable(sticky_invalid) && $stable(sticky_inexact)
                                        && !res_invalid && !res_inexact));
    p_sticky_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sticky_invalid) || $rose(sticky_inexact)) |-> $past(op_valid));
endmodule

// File: tb/pcvt_f2u_vec_tb_top.sv
module pcvt_f2u_vec_tb_top;
    localparam int LANES = 16;
    localparam int VW    = LANES * 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             op_valid = 1'b0;
    logic [VW-1:0]    src_vec = '0;
    logic [VW-1:0]    old_dst = '0;
    logic [LANES-1:0] wr_mask = '0;
    logic             zero_en = 1'b0;
    logic             bcast_en = 1'b0;
    logic             static_rc_en = 1'b0;
    logic [1:0]       static_rc = '0;
    logic [1:0]       glob_rc = '0;
    logic             res_valid, res_invalid, res_inexact, sticky_invalid, sticky_inexact;
    logic [VW-1:0]    res_vec;

    int  n_chk = 0;
    int  n_fail = 0;
    logic exp_sinv = 1'b0;
    logic exp_sinx = 1'b0;

    always #5 clk = ~clk;

    pcvt_f2u_vec #(.LANES(LANES)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .src_vec(src_vec),
        .old_dst(old_dst), .wr_mask(wr_mask), .zero_en(zero_en), .bcast_en(bcast_en),
        .static_rc_en(static_rc_en), .static_rc(static_rc), .glob_rc(glob_rc),
        .res_valid(res_valid), .res_vec(res_vec), .res_invalid(res_invalid),
        .res_inexact(res_inexact), .sticky_invalid(sticky_invalid),
        .sticky_inexact(sticky_inexact)
    );

    function automatic logic [31:0] val_of(int idx);
        case (idx)
            0: return 32'h3F000000;  1: return 32'hBF000000;
            2: return 32'h3FC00000;  3: return 32'h40200000;
            4: return 32'h3FA00000;  5: return 32'h3FE00000;
            6: return 32'h4F7FFFFF;  7: return 32'h4F800000;
            8: return 32'h3F800000;  9: return 32'h40400000;
            10: return 32'h80000000; 11: return 32'h7FC00000;
            12: return 32'h7F800000; 13: return 32'hBF800000;
            14: return 32'h3F400000; default: return 32'hBF400000;
        endcase
    endfunction

    // {invalid, inexact, value}; mode 0 nearest-even, 1 down, 2 up, 3 toward zero
    function automatic logic [33:0] exp_of(int idx, int m);
        logic [33:0] inv_r;
        inv_r = {2'b10, 32'hFFFFFFFF};
        case (idx)
            0: return {2'b01, (m == 2) ? 32'd1 : 32'd0};
            1: return (m == 1) ? inv_r : {2'b01, 32'd0};
            2: return {2'b01, (m == 1 || m == 3) ? 32'd1 : 32'd2};
            3: return {2'b01, (m == 2) ? 32'd3 : 32'd2};
            4: return {2'b01, (m == 2) ? 32'd2 : 32'd1};
            5: return {2'b01, (m == 1 || m == 3) ? 32'd1 : 32'd2};
            6: return {2'b00, 32'hFFFFFF00};
            8: return {2'b00, 32'd1};
            9: return {2'b00, 32'd3};
            10: return {2'b00, 32'd0};
            14: return {2'b01, (m == 0 || m == 2) ? 32'd1 : 32'd0};
            15: return (m <= 1) ? inv_r : {2'b01, 32'd0};
            default: return inv_r;
        endcase
    endfunction

    function automatic logic [VW-1:0] table_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < LANES; i++) v[i*32 +: 32] = val_of(i);
        return v;
    endfunction

    function automatic logic [VW-1:0] old_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < LANES; i++) v[i*32 +: 32] = 32'hA5A50000 | 32'(i);
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(logic [VW-1:0] src, logic [LANES-1:0] m, logic z, logic b,
                         logic sen, logic [1:0] src_rc, logic [1:0] grc);
        @(negedge clk);
        src_vec = src; old_dst = old_vec(); wr_mask = m; zero_en = z; bcast_en = b;
        static_rc_en = sen; static_rc = src_rc; glob_rc = grc; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic expect_result(string req, logic [LANES-1:0] m, logic z, int mode,
                                 int bidx, logic sen);
        logic e_inv, e_inx;
        logic [33:0] e;
        logic [31:0] ev;
        e_inv = 1'b0; e_inx = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            e = exp_of((bidx >= 0) ? bidx : i, mode);
            if (m[i]) begin
                ev = e[31:0]; e_inv |= e[33]; e_inx |= e[32];
            end else begin
                ev = z ? 32'd0 : (32'hA5A50000 | 32'(i));
            end
            chk(req, res_vec[i*32 +: 32], ev);
        end
        chk({req, " R1 valid"}, 32'(res_valid), 32'd1);
        chk({req, " R8 inv"}, 32'(res_invalid), 32'(e_inv & ~sen));
        chk({req, " R8 inx"}, 32'(res_inexact), 32'(e_inx & ~sen));
        if (!sen) begin exp_sinv |= e_inv; exp_sinx |= e_inx; end
        chk({req, " R10 sinv"}, 32'(sticky_invalid), 32'(exp_sinv));
        chk({req, " R10 sinx"}, 32'(sticky_inexact), 32'(exp_sinx));
    endtask

    task automatic t_reset();
        chk("R1 reset valid", 32'(res_valid), 32'd0);
        chk("R1 reset vec", res_vec[31:0], 32'd0);
        chk("R1 reset inv", 32'(res_invalid), 32'd0);
        chk("R10 reset sticky", 32'({sticky_invalid, sticky_inexact}), 32'd0);
    endtask

    task automatic t_override();
        // R3 R9: static code wins over the global field; flags silent, saturation kept
        issue(table_vec(), 16'hFFFF, 1'b0, 1'b0, 1'b1, 2'd3, 2'd0);
        expect_result("R3 R9 static zero", 16'hFFFF, 1'b0, 3, -1, 1'b1);
        issue(table_vec(), 16'hFFFF, 1'b0, 1'b0, 1'b1, 2'd2, 2'd3);
        expect_result("R3 R4 static up", 16'hFFFF, 1'b0, 2, -1, 1'b1);
    endtask

    task automatic t_round_modes();
        // R2 R4 R10: every global mode over the halfway, +-0.5 and 2^32 lanes
        for (int md = 0; md < 4; md++) begin
            issue(table_vec(), 16'hFFFF, 1'b0, 1'b0, 1'b0, 2'd0, 2'(md));
            expect_result("R2 R4 global mode", 16'hFFFF, 1'b0, md, -1, 1'b0);
        end
    endtask

    task automatic t_mask_merge();
        logic [LANES-1:0] m;
        // R8: only exact lanes written, so invalid/inexact lanes are masked off
        issue(table_vec(), 16'h0740, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1);
        expect_result("R5 R8 masked flags", 16'h0740, 1'b0, 1, -1, 1'b0);
        for (int k = 0; k < 6; k++) begin
            m = 16'($urandom);
            issue(table_vec(), m, 1'b0, 1'b0, 1'b0, 2'd0, 2'(k));
            expect_result("R5 merge random", m, 1'b0, k % 4, -1, 1'b0);
        end
    endtask

    task automatic t_zero();
        logic [LANES-1:0] m;
        for (int k = 0; k < 6; k++) begin
            m = 16'($urandom);
            issue(table_vec(), m, 1'b1, 1'b0, 1'b0, 2'(k), 2'd0);
            expect_result("R6 zero random", m, 1'b1, 0, -1, 1'b0);
        end
    endtask

    task automatic t_bcast();
        logic [VW-1:0] s;
        s = '1;
        s[31:0] = val_of(3);
        issue(s, 16'hFFFF, 1'b0, 1'b1, 1'b0, 2'd0, 2'd2);
        expect_result("R7 bcast 2.5 up", 16'hFFFF, 1'b0, 2, 3, 1'b0);
        s[31:0] = val_of(1);
        issue(s, 16'h5555, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0);
        expect_result("R7 R4 bcast -0.5", 16'h5555, 1'b1, 0, 1, 1'b0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        chk("R1 valid drops", 32'(res_valid), 32'd0);
        chk("R10 sticky held", 32'({sticky_invalid, sticky_inexact}),
            32'({exp_sinv, exp_sinx}));
    endtask

    initial begin
        void'($urandom(17));
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_override();
        t_round_modes();
        t_mask_merge();
        t_zero();
        t_bcast();
        t_idle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule